// File: doc/BRIEF.md
# Serial-to-Parallel Word Deserializer with Bit Order and Squelch

This block turns a recovered serial bit stream into 16-bit parallel words. Every stage runs on the fast bit clock. One bit is taken on each rising edge, and a registered word clock at one sixteenth of the bit rate marks where each word begins. A static fill-order input chooses where the first bit of each word lands. With `first_to_msb` low it goes to bit 0. With `first_to_msb` high it goes to bit 15.

An active-low quiet input forces the parallel word to zero. Bits keep being collected while the output is quiet, so valid data comes back at the first word boundary after the quiet input is released. An auxiliary clock comes from the same phase counter. It can run at 1/16 or 1/64 of the bit rate, and an off input holds it low.

The data path has no valid/ready handshake and takes no back-pressure. The source is a recovered line clock, so it cannot be stalled. Each word is held for exactly 16 bit clocks, and a downstream consumer captures it on the rising edge of `word_clk`.

Top module: `bitstream_deser`

## Requirements
- R1: The first bit clock edge after reset is released takes bit 0 of a word. Each later group of 16 consecutive bits forms one word, and the bit counter wraps after every 16 bits.
- R2: `word_data` changes only on the bit clock edge that takes the 16th bit of a word, unless the quiet input clears it. On that same edge `word_clk` rises. `word_clk` then stays high for 8 bit clocks and low for 8.
- R3: With `first_to_msb` = 0, the first bit received goes to `word_data[0]` and the following bits fill bits 1 to 15 in order.
- R4: With `first_to_msb` = 1, the first bit received goes to `word_data[15]` and the following bits fill bits 14 down to 0.
- R5: While `quiet_n` is low, `word_data` is zero from the next bit clock edge onward.
- R6: After `quiet_n` rises, `word_data` stays zero until the next word boundary. At that boundary it loads the full word, including any bits received while the output was quiet.
- R7: With `aux_slow` = 0 and `aux_off` = 0, `aux_clk` equals `word_clk` in every cycle.
- R8: With `aux_slow` = 1 and `aux_off` = 0, `aux_clk` has a period of 64 bit clocks. It is high for 32 and low for 32, and it rises together with every fourth rise of `word_clk`.
- R9: With `aux_off` = 1, `aux_clk` is low from the next bit clock edge onward.
- R10: A synchronous reset with `rst_n` low clears the bit counter, the collected bits and `word_data`. In reset, `word_clk` sits high, and `aux_clk` sits high unless `aux_off` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; every register samples on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| ser_bit | input | 1 | Serial data bit |
| first_to_msb | input | 1 | Fill order: 0 puts the first bit in bit 0, 1 puts it in bit 15 |
| quiet_n | input | 1 | Output squelch, active low |
| aux_slow | input | 1 | Auxiliary clock rate: 0 gives /16, 1 gives /64 |
| aux_off | input | 1 | Holds the auxiliary clock low when high |
| word_clk | output | 1 | Bit clock divided by 16; rises when a new word is presented |
| word_data | output | 16 | Parallel word |
| aux_clk | output | 1 | Auxiliary divided clock |

## Verification
Walking-one sweeps in both fill orders show that each received bit position lands on its own output bit. A mirrored mapping or an off-by-one position gives a different single-bit word. Dense, sparse, all-ones and all-zero words separate stuck bits from stale bits held over from the previous word. Quiet input pulses that start in the middle of a word, span a boundary, and are released before a boundary separate an immediate clear from a late clear, and a late reload from an early one. A cycle-by-cycle model compares both clocks in every cycle while the auxiliary rate and its off input are switched at arbitrary points.

// File: rtl/deser_pkg.sv
package deser_pkg;

  // Default geometry: word width and the extra divide of the slow auxiliary mode.
  // Both must be powers of two.
  localparam int unsigned DSR_WORD_W    = 16;
  localparam int unsigned DSR_SLOW_MULT = 4;

  typedef enum logic {
    FILL_FROM_LSB = 1'b0,
    FILL_FROM_MSB = 1'b1
  } fill_order_e;

endpackage

// File: rtl/deser_phase_ctr.sv
module deser_phase_ctr #(
  parameter int unsigned WORD_W    = 16,
  parameter int unsigned SLOW_MULT = 4,
  localparam int unsigned CNT_W    = $clog2(WORD_W * SLOW_MULT),
  localparam int unsigned IDX_W    = $clog2(WORD_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] cnt_nxt,
  output logic [IDX_W-1:0] idx,
  output logic             boundary,
  output logic             word_clk
);

  localparam logic [CNT_W-1:0] CNT_TOP  = CNT_W'(WORD_W * SLOW_MULT - 1);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(WORD_W - 1);
  localparam logic [IDX_W-1:0] IDX_HALF = IDX_W'(WORD_W / 2);

  assign cnt_nxt  = (cnt == CNT_TOP) ? '0 : cnt + CNT_W'(1);
  assign idx      = cnt[IDX_W-1:0];
  assign boundary = (idx == IDX_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt      <= '0;
      word_clk <= 1'b1;
    end else begin
      cnt      <= cnt_nxt;
      word_clk <= (cnt_nxt[IDX_W-1:0] < IDX_HALF);
    end
  end

  // R1: the bit index returns to zero after the last bit of a word
  p_idx_wraps_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(boundary)) |-> (idx == '0));

  // R2: the word clock rises only right after the last bit of a word
  p_wclk_rise_boundary_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $rose(word_clk)) |-> $past(boundary));

endmodule

// File: rtl/deser_collect.sv
module deser_collect
  import deser_pkg::*;
#(
  parameter int unsigned WORD_W = 16,
  localparam int unsigned IDX_W = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_bit,
  input  fill_order_e       order,
  input  logic [IDX_W-1:0]  idx,
  output logic [WORD_W-1:0] merged
);

  logic [WORD_W-1:0] coll;
  logic [WORD_W-1:0] hit;

  // Each output position decodes its own write index for both fill orders.
  for (genvar j = 0; j < WORD_W; j++) begin : g_slot
    localparam logic [IDX_W-1:0] FWD = IDX_W'(j);
    localparam logic [IDX_W-1:0] REV = IDX_W'(WORD_W - 1 - j);
    assign hit[j]    = (order == FILL_FROM_MSB) ? (idx == REV) : (idx == FWD);
    assign merged[j] = hit[j] ? ser_bit : coll[j];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) coll <= '0;
    else        coll <= merged;
  end

  // R3 / R4: exactly one slot takes the incoming bit in every cycle
  p_one_slot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(hit) == 1);

endmodule

// File: rtl/deser_out_stage.sv
module deser_out_stage #(
  parameter int unsigned WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              boundary,
  input  logic              quiet_n,
  input  logic [WORD_W-1:0] merged,
  output logic [WORD_W-1:0] word_data
);

  always_ff @(posedge clk) begin
    if (!rst_n)        word_data <= '0;
    else if (!quiet_n) word_data <= '0;
    else if (boundary) word_data <= merged;
  end

  // R5: a quiet cycle leaves a zero word behind it
  p_squelch_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(quiet_n)) |-> (word_data == '0));

  // R2: the word holds between boundaries
  p_hold_midword_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(boundary)) |-> ($stable(word_data) || (word_data == '0)));

endmodule

// File: rtl/deser_aux_clk.sv
module deser_aux_clk #(
  parameter int unsigned WORD_W    = 16,
  parameter int unsigned SLOW_MULT = 4,
  localparam int unsigned CNT_W    = $clog2(WORD_W * SLOW_MULT),
  localparam int unsigned IDX_W    = $clog2(WORD_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt_nxt,
  input  logic             word_clk,
  input  logic             aux_slow,
  input  logic             aux_off,
  output logic             aux_clk
);

  localparam logic [IDX_W-1:0] IDX_HALF = IDX_W'(WORD_W / 2);

  logic fast_lvl;
  logic slow_lvl;

  assign fast_lvl = (cnt_nxt[IDX_W-1:0] < IDX_HALF);

  if (SLOW_MULT > 1) begin : g_slow
    localparam logic [CNT_W-1:0] CNT_HALF = CNT_W'(WORD_W * SLOW_MULT / 2);
    assign slow_lvl = (cnt_nxt < CNT_HALF);
  end else begin : g_same
    assign slow_lvl = fast_lvl;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       aux_clk <= !aux_off;
    else if (aux_off) aux_clk <= 1'b0;
    else              aux_clk <= aux_slow ? slow_lvl : fast_lvl;
  end

  // R9: a disabled auxiliary clock sits low
  p_aux_off_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(aux_off)) |-> !aux_clk);

  // R7: fast auxiliary mode tracks the word clock
  p_aux_fast_aligned_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(!aux_off && !aux_slow)) |-> (aux_clk == word_clk));

endmodule

// File: rtl/bitstream_deser.sv
module bitstream_deser
  import deser_pkg::*;
#(
  parameter int unsigned WORD_W    = DSR_WORD_W,
  parameter int unsigned SLOW_MULT = DSR_SLOW_MULT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_bit,
  input  logic              first_to_msb,
  input  logic              quiet_n,
  input  logic              aux_slow,
  input  logic              aux_off,
  output logic              word_clk,
  output logic [WORD_W-1:0] word_data,
  output logic              aux_clk
);

  localparam int unsigned CNT_W = $clog2(WORD_W * SLOW_MULT);
  localparam int unsigned IDX_W = $clog2(WORD_W);

  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  cnt_nxt;
  logic [IDX_W-1:0]  idx;
  logic              boundary;
  logic [WORD_W-1:0] merged;
  fill_order_e       order;

  assign order = fill_order_e'(first_to_msb);

  deser_phase_ctr #(.WORD_W(WORD_W), .SLOW_MULT(SLOW_MULT)) u_phase (
    .clk(clk), .rst_n(rst_n), .cnt(cnt), .cnt_nxt(cnt_nxt), .idx(idx),
    .boundary(boundary), .word_clk(word_clk)
  );

  deser_collect #(.WORD_W(WORD_W)) u_collect (
    .clk(clk), .rst_n(rst_n), .ser_bit(ser_bit), .order(order), .idx(idx),
    .merged(merged)
  );

  deser_out_stage #(.WORD_W(WORD_W)) u_out (
    .clk(clk), .rst_n(rst_n), .boundary(boundary), .quiet_n(quiet_n),
    .merged(merged), .word_data(word_data)
  );

  deser_aux_clk #(.WORD_W(WORD_W), .SLOW_MULT(SLOW_MULT)) u_aux (
    .clk(clk), .rst_n(rst_n), .cnt_nxt(cnt_nxt), .word_clk(word_clk),
    .aux_slow(aux_slow), .aux_off(aux_off), .aux_clk(aux_clk)
  );

  // R10: the first cycle out of reset shows the reset state
  p_reset_state_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> ((word_data == '0) && word_clk && (cnt == '0)));

  // R8: the slow auxiliary clock never rises while the word clock is low
  p_aux_rise_with_word_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $rose(aux_clk) && $past(aux_slow) && !$past(aux_off)
     && $past(cnt == '0)) |-> word_clk);

endmodule

// File: tb/bitstream_deser_test.sv
`timescale 1ns/1ps
module bitstream_deser_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ser_bit = 1'b0;
  logic        first_to_msb = 1'b0;
  logic        quiet_n = 1'b1;
  logic        aux_slow = 1'b0;
  logic        aux_off = 1'b0;
  logic        word_clk;
  logic [15:0] word_data;
  logic        aux_clk;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  bit mon_on = 1'b0;

  always #2.5 clk = ~clk;

  bitstream_deser uut (
    .clk(clk), .rst_n(rst_n), .ser_bit(ser_bit), .first_to_msb(first_to_msb),
    .quiet_n(quiet_n), .aux_slow(aux_slow), .aux_off(aux_off),
    .word_clk(word_clk), .word_data(word_data), .aux_clk(aux_clk)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act %h exp %h at %0t", tag, act, exp, $time);
    end
  endtask

  // Cycle model built from the requirements
  int          n = 0;
  logic [15:0] m_coll = '0;
  logic [15:0] m_data = '0;
  logic        m_wclk = 1'b1;
  logic        m_aux = 1'b1;

  always @(posedge clk) begin
    if (!rst_n) begin
      n = 0; m_coll = '0; m_data = '0; m_wclk = 1'b1; m_aux = !aux_off;
    end else begin
      int k;
      k = n % 16;
      m_coll[first_to_msb ? 15 - k : k] = ser_bit;
      if (!quiet_n) m_data = '0;
      else if (k == 15) m_data = m_coll;
      n = (n + 1) % 64;
      m_wclk = (n % 16) < 8;
      m_aux = aux_off ? 1'b0 : (aux_slow ? (n < 32) : ((n % 16) < 8));
    end
  end

  always @(negedge clk) begin
    if (mon_on) begin
      chk("R2 word held between boundaries", word_data, m_data);
      chk("R2 word clock phase", {15'd0, word_clk}, {15'd0, m_wclk});
      if (aux_off)       chk("R9 aux clock held low", {15'd0, aux_clk}, {15'd0, m_aux});
      else if (aux_slow) chk("R8 aux clock /64", {15'd0, aux_clk}, {15'd0, m_aux});
      else               chk("R7 aux clock /16", {15'd0, aux_clk}, {15'd0, m_aux});
    end
  end

  function automatic logic [15:0] rev16(input logic [15:0] v);
    logic [15:0] r;
    for (int i = 0; i < 16; i++) r[15 - i] = v[i];
    return r;
  endfunction

  // Starts and ends at a falling edge; bit i of pat is the i-th received bit.
  task automatic send_word(input logic [15:0] pat, input logic msb, input string tag,
                           input int sq_lo, input int sq_hi);
    logic [15:0] exp;
    first_to_msb = msb;
    for (int i = 0; i < 16; i++) begin
      if (i == sq_lo) quiet_n = 1'b0;
      if (i == sq_hi) quiet_n = 1'b1;
      ser_bit = pat[i];
      @(negedge clk);
      if (i == sq_lo) chk("R5 quiet clears word next edge", word_data, 16'h0000);
      if (i == sq_hi) chk("R6 zero until next boundary", word_data, 16'h0000);
    end
    exp = quiet_n ? (msb ? rev16(pat) : pat) : 16'h0000;
    chk(tag, word_data, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R1 watchdog act running exp finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    chk("R10 reset word", word_data, 16'h0000);
    chk("R10 reset word clock high", {15'd0, word_clk}, 16'h0001);
    chk("R10 reset aux clock high", {15'd0, aux_clk}, 16'h0001);
    rst_n = 1'b1;
    mon_on = 1'b1;

    send_word(16'hA5C3, 1'b0, "R1 first word after reset", -1, -1);
    send_word(16'h3C5A, 1'b0, "R1 second word", -1, -1);
    for (int b = 0; b < 16; b++)
      send_word(16'h0001 << b, 1'b0, "R3 walking one first-to-lsb", -1, -1);
    send_word(16'h0001, 1'b0, "R3 first bit on bit 0", -1, -1);
    aux_slow = 1'b1;
    for (int b = 0; b < 16; b++)
      send_word(16'h0001 << b, 1'b1, "R4 walking one first-to-msb", -1, -1);
    send_word(16'h0001, 1'b1, "R4 first bit on bit 15", -1, -1);
    send_word(16'hFFFF, 1'b1, "R4 all ones", -1, -1);
    aux_off = 1'b1;
    send_word(16'h0000, 1'b0, "R9 all zeros with aux off", -1, -1);
    send_word(16'h8E17, 1'b1, "R9 word with aux off", -1, -1);
    aux_off = 1'b0;
    send_word(16'h1248, 1'b0, "R8 slow aux restarts", -1, -1);
    aux_slow = 1'b0;
    send_word(16'hFFFF, 1'b0, "R7 fast aux word", -1, -1);
    send_word(16'h7777, 1'b0, "R5 quiet from mid word", 5, -1);
    send_word(16'h1111, 1'b0, "R5 quiet across boundary", -1, -1);
    send_word(16'hC0DE, 1'b1, "R6 bits kept while quiet", -1, 3);
    send_word(16'hBEEF, 1'b0, "R6 normal after release", -1, -1);
    send_word(16'h2222, 1'b0, "R5 quiet on last bit", 15, -1);
    send_word(16'h4321, 1'b0, "R6 release on first bit", -1, 0);
    aux_off = 1'b1;
    repeat (5) @(negedge clk);
    aux_off = 1'b0;
    aux_slow = 1'b1;
    repeat (70) @(negedge clk);

    mon_on = 1'b0;
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule